// File: doc/BRIEF.md
# Staged Power-Up Sequencer with System Reset Control

This block brings a machine's supplies up in stages and produces its machine-wide reset lines. When the operator raises the power request, the block closes the main contactor and starts a delay timer. Three rail-good flags are combined into a single primary-good condition. Once that condition holds, the block switches on the path that feeds the two auxiliary rails and lights the power lamp. If the delay runs out without primary-good, the block opens the contactor and sets a self-holding lockout. Only a service clear switch or a full reset releases that lockout.

The active-low power-on reset is released only after the timer has expired with good power. The active-low system reset follows it. The system reset also goes low when the operator's reset key is held while the machine is stopped. All asynchronous inputs pass through two-flop synchronizers. The reset key is debounced in units of a prescaled tick, and the same tick drives the delay timer.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: Primary-good is the AND of the three rail-good inputs; with any one of them low, `aux_en_o` and `lamp_o` stay 0.
- R2: While the contactor is enabled, `aux_en_o` and `lamp_o` are 1 whenever primary-good holds, both during the wait and after a successful start.
- R3: If the timer reaches `TIMEOUT_TICKS` ticks while primary-good is low, `contactor_en_o` drops to 0 and `lockout_o` becomes 1.
- R4: While `lockout_o` is 1, power requests have no effect and the contactor stays off. A pulse on `svc_clear_i` or an assertion of `rst_ni` returns the block to the off state with `lockout_o` at 0.
- R5: `por_n_o` stays 0 throughout the wait. It goes to 1 only after the timer expires with primary-good asserted.
- R6: `sys_rst_n_o` is 0 whenever `por_n_o` is 0.
- R7: With `por_n_o` at 1, `sys_rst_n_o` is 0 exactly while the debounced reset key is pressed (`reset_key_ni` = 0) and `run_i` is 0. A key press while `run_i` is 1 has no effect.
- R8: If primary-good drops after a successful start, `aux_en_o`, `lamp_o`, `contactor_en_o` and `por_n_o` all go to 0, and the block enters the off state without setting `lockout_o`.
- R9: A start needs a rising edge on `pwr_req_i`. A request that is merely held does not restart the block. Dropping the request during the wait or after a start returns the block to the off state.
- R10: A change on the reset key is accepted only after it has held steady for `DEBOUNCE_TICKS` ticks. A shorter pulse leaves `sys_rst_n_o` unchanged.
- R11: After `rst_ni`, all enables and `lockout_o` are 0, and `por_n_o` and `sys_rst_n_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; models full power removal |
| rail_good_i | input | 3 | Rail-good flags of the three main supplies |
| pwr_req_i | input | 1 | Operator power request (level; rising edge starts) |
| svc_clear_i | input | 1 | Service switch that releases the lockout |
| reset_key_ni | input | 1 | Operator reset key, active low |
| run_i | input | 1 | Machine run state |
| contactor_en_o | output | 1 | Main contactor enable |
| aux_en_o | output | 1 | Auxiliary supply path enable |
| lamp_o | output | 1 | Power lamp |
| lockout_o | output | 1 | Lockout indicator |
| por_n_o | output | 1 | Power-on reset, active low |
| sys_rst_n_o | output | 1 | System reset, active low |

## Verification
The hardest situation to reach from the ports is a lockout that has to be released. The bench must first let the full timeout run with a partial rail set. It then re-pulses the request and supplies good rails, and must show that neither one restarts the block. Only after that does it clear the lockout, once by the service switch and once by reset. The stimulus walks through this directly, drawing the partial rail pattern at random from the seven non-good codes. The key and run combinations are likewise drawn at random in the powered state, and the bench checks the system reset against a function of the expected power-on reset, debounced key and run flag.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [1:0] {
        ST_OFF        = 2'd0,
        ST_WAIT_RAILS = 2'd1,
        ST_POWERED    = 2'd2,
        ST_LOCKED     = 2'd3
    } pwr_state_e;

    localparam int unsigned NUM_RAILS = 3;
    // synchronized input bundle layout
    localparam int unsigned SYNC_W   = NUM_RAILS + 4;
    localparam int unsigned IDX_RUN  = 0;
    localparam int unsigned IDX_KEY  = 1;
    localparam int unsigned IDX_CLR  = 2;
    localparam int unsigned IDX_REQ  = 3;
    localparam int unsigned IDX_RAIL = 4;

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int unsigned       WIDTH   = 1,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] sync;
    } sync_regs_t;

    sync_regs_t regs_d, regs_q;

    always_comb begin
        regs_d      = regs_q;
        regs_d.meta = async_i;
        regs_d.sync = regs_q.meta;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q.meta <= RST_VAL;
            regs_q.sync <= RST_VAL;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign sync_o = regs_q.sync;

endmodule

// File: rtl/pwrseq_tick.sv
module pwrseq_tick #(
    parameter int unsigned TICK_DIV = 250000
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);

    localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_regs_t;

    tick_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (regs_q.cnt == LAST) begin
            regs_d.cnt  = '0;
            regs_d.tick = 1'b1;
        end else begin
            regs_d.cnt  = regs_q.cnt + 1'b1;
            regs_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign tick_o = regs_q.tick;

    // tick is a single-cycle pulse whenever the divider exceeds one
    assert_tick_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (TICK_DIV > 1 && tick_o) |=> !tick_o);

endmodule

// File: rtl/pwrseq_debounce.sv
module pwrseq_debounce #(
    parameter int unsigned DEBOUNCE_TICKS = 20
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic key_n_i,
    output logic pressed_o
);

    localparam int unsigned CW = $clog2(DEBOUNCE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_TICKS - 1);

    typedef struct packed {
        logic          stable_n;
        logic [CW-1:0] cnt;
    } deb_regs_t;

    deb_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (key_n_i == regs_q.stable_n) begin
            regs_d.cnt = '0;
        end else if (tick_i) begin
            if (regs_q.cnt >= LAST) begin
                regs_d.stable_n = key_n_i;
                regs_d.cnt      = '0;
            end else begin
                regs_d.cnt = regs_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q.stable_n <= 1'b1;
            regs_q.cnt      <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign pressed_o = !regs_q.stable_n;

    // accepted key level changes only on a tick
    assert_key_on_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(regs_q.stable_n) |-> $past(tick_i));

    assert_cnt_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        regs_q.cnt <= LAST);

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int unsigned TIMEOUT_TICKS = 5000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic prim_good_i,
    input  logic req_i,
    input  logic clr_i,
    output logic contactor_o,
    output logic aux_o,
    output logic por_n_o,
    output logic locked_o
);

    localparam int unsigned TW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT_TICKS - 1);

    typedef struct packed {
        pwr_state_e    state;
        logic [TW-1:0] timer;
        logic          req_prev;
        logic          contactor;
        logic          aux;
        logic          por_n;
    } fsm_regs_t;

    fsm_regs_t regs_d, regs_q;
    logic      req_rise;
    logic      expire;

    always_comb begin
        req_rise = req_i && !regs_q.req_prev;
        expire   = tick_i && (regs_q.timer == LAST);
        regs_d   = regs_q;
        regs_d.req_prev = req_i;

        unique case (regs_q.state)
            ST_OFF: begin
                regs_d.timer = '0;
                if (req_rise) begin
                    regs_d.state = ST_WAIT_RAILS;
                end
            end
            ST_WAIT_RAILS: begin
                if (!req_i) begin
                    regs_d.state = ST_OFF;
                end else if (expire) begin
                    regs_d.state = prim_good_i ? ST_POWERED : ST_LOCKED;
                end else if (tick_i) begin
                    regs_d.timer = regs_q.timer + 1'b1;
                end
            end
            ST_POWERED: begin
                if (!req_i || !prim_good_i) begin
                    regs_d.state = ST_OFF;
                end
            end
            ST_LOCKED: begin
                if (clr_i) begin
                    regs_d.state = ST_OFF;
                end
            end
            default: regs_d.state = ST_OFF;
        endcase

        regs_d.contactor = (regs_d.state == ST_WAIT_RAILS) ||
                           (regs_d.state == ST_POWERED);
        regs_d.aux       = regs_d.contactor && prim_good_i;
        regs_d.por_n     = (regs_d.state == ST_POWERED);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q.state     <= ST_OFF;
            regs_q.timer     <= '0;
            regs_q.req_prev  <= 1'b0;
            regs_q.contactor <= 1'b0;
            regs_q.aux       <= 1'b0;
            regs_q.por_n     <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign contactor_o = regs_q.contactor;
    assign aux_o       = regs_q.aux;
    assign por_n_o     = regs_q.por_n;
    assign locked_o    = (regs_q.state == ST_LOCKED);

    assert_aux_needs_rails_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        aux_o |-> $past(prim_good_i));

    assert_aux_with_contactor_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (contactor_o && prim_good_i && regs_q.state == ST_POWERED) |=> (aux_o || !contactor_o));

    assert_lock_drops_contactor_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked_o |-> !contactor_o);

    assert_lock_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked_o && !clr_i) |=> locked_o);

    assert_por_after_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(por_n_o) |-> ($past(regs_q.state) == ST_WAIT_RAILS && $past(prim_good_i)));

    assert_rail_drop_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (regs_q.state == ST_POWERED && !prim_good_i) |=> (regs_q.state == ST_OFF && !por_n_o));

    assert_timer_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        regs_q.timer <= LAST);

endmodule

// File: rtl/pwrseq_rstgen.sv
module pwrseq_rstgen (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic por_n_i,
    input  logic key_pressed_i,
    input  logic run_i,
    output logic sys_rst_n_o
);

    typedef struct packed {
        logic sys_rst_n;
    } rst_regs_t;

    rst_regs_t regs_d, regs_q;

    always_comb begin
        regs_d           = regs_q;
        regs_d.sys_rst_n = por_n_i && !(key_pressed_i && !run_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q.sys_rst_n <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign sys_rst_n_o = regs_q.sys_rst_n;

    assert_por_forces_reset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !por_n_i |=> !sys_rst_n_o);

    assert_run_masks_key_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (por_n_i && run_i) |=> sys_rst_n_o);

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int unsigned TICK_DIV       = 250000,
    parameter int unsigned TIMEOUT_TICKS  = 5000,
    parameter int unsigned DEBOUNCE_TICKS = 20
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] rail_good_i,
    input  logic       pwr_req_i,
    input  logic       svc_clear_i,
    input  logic       reset_key_ni,
    input  logic       run_i,
    output logic       contactor_en_o,
    output logic       aux_en_o,
    output logic       lamp_o,
    output logic       lockout_o,
    output logic       por_n_o,
    output logic       sys_rst_n_o
);

    localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(1) << IDX_KEY;

    logic [SYNC_W-1:0]    raw_in;
    logic [SYNC_W-1:0]    sync_in;
    logic [NUM_RAILS-1:0] rails_s;
    logic                 prim_good;
    logic                 tick;
    logic                 key_pressed;
    logic                 por_n;

    assign raw_in = {rail_good_i, pwr_req_i, svc_clear_i, reset_key_ni, run_i};

    pwrseq_sync #(
        .WIDTH   (SYNC_W),
        .RST_VAL (SYNC_RST)
    ) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    assign rails_s   = sync_in[IDX_RAIL +: NUM_RAILS];
    assign prim_good = &rails_s;

    pwrseq_tick #(
        .TICK_DIV (TICK_DIV)
    ) i_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    pwrseq_debounce #(
        .DEBOUNCE_TICKS (DEBOUNCE_TICKS)
    ) i_debounce (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .key_n_i   (sync_in[IDX_KEY]),
        .pressed_o (key_pressed)
    );

    pwrseq_fsm #(
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) i_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick),
        .prim_good_i (prim_good),
        .req_i       (sync_in[IDX_REQ]),
        .clr_i       (sync_in[IDX_CLR]),
        .contactor_o (contactor_en_o),
        .aux_o       (aux_en_o),
        .por_n_o     (por_n),
        .locked_o    (lockout_o)
    );

    pwrseq_rstgen i_rstgen (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .por_n_i       (por_n),
        .key_pressed_i (key_pressed),
        .run_i         (sync_in[IDX_RUN]),
        .sys_rst_n_o   (sys_rst_n_o)
    );

    assign lamp_o  = aux_en_o;
    assign por_n_o = por_n;

    assert_lock_no_power_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lockout_o |-> (!contactor_en_o && !aux_en_o && !por_n_o));

endmodule

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;

    localparam int unsigned TB_DIV = 4;
    localparam int unsigned TB_TO  = 20;
    localparam int unsigned TB_DEB = 3;
    localparam int LONG = 160;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] rails = 3'b000;
    logic       req = 1'b0;
    logic       clr = 1'b0;
    logic       key_n = 1'b1;
    logic       run = 1'b0;
    logic       contactor, aux, lamp, lockout, por_n, sys_rst_n;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pwr_seq_ctrl #(
        .TICK_DIV       (TB_DIV),
        .TIMEOUT_TICKS  (TB_TO),
        .DEBOUNCE_TICKS (TB_DEB)
    ) i_pwr_seq_ctrl (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .rail_good_i    (rails),
        .pwr_req_i      (req),
        .svc_clear_i    (clr),
        .reset_key_ni   (key_n),
        .run_i          (run),
        .contactor_en_o (contactor),
        .aux_en_o       (aux),
        .lamp_o         (lamp),
        .lockout_o      (lockout),
        .por_n_o        (por_n),
        .sys_rst_n_o    (sys_rst_n)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req_tag, input string what, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got=%0b exp=%0b", req_tag, what, got, exp);
        end
    endtask

    function automatic logic exp_sys(input logic por, input logic pressed, input logic running);
        return por && !(pressed && !running);
    endfunction

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [2:0] bad;
        void'($urandom(32'd20220508));

        // R11 reset state
        cyc(5);
        chk("R11", "contactor", contactor, 1'b0);
        chk("R11", "aux", aux, 1'b0);
        chk("R11", "lockout", lockout, 1'b0);
        chk("R11", "por_n", por_n, 1'b0);
        chk("R11", "sys_rst_n", sys_rst_n, 1'b0);
        rst_n = 1'b1;
        cyc(5);

        // successful start
        rails = 3'b111;
        cyc(10);
        chk("R2", "aux before request", aux, 1'b0);
        req = 1'b1;
        cyc(30);
        chk("R2", "contactor in wait", contactor, 1'b1);
        chk("R2", "aux in wait", aux, 1'b1);
        chk("R2", "lamp in wait", lamp, 1'b1);
        chk("R5", "por_n in wait", por_n, 1'b0);
        chk("R6", "sys_rst_n in wait", sys_rst_n, 1'b0);
        cyc(LONG);
        chk("R5", "por_n after start", por_n, 1'b1);
        chk("R7", "sys_rst_n after start", sys_rst_n, exp_sys(1'b1, 1'b0, 1'b0));
        chk("R3", "no lockout", lockout, 1'b0);

        // R10 short key pulse ignored
        run = 1'b0;
        key_n = 1'b0;
        cyc(TB_DIV);
        key_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            cyc(6);
            chk("R10", "short pulse", sys_rst_n, 1'b1);
        end

        // R7 directed: press while stopped, then while running
        key_n = 1'b0;
        cyc(40);
        chk("R7", "key stopped", sys_rst_n, exp_sys(1'b1, 1'b1, 1'b0));
        key_n = 1'b1;
        cyc(40);
        chk("R7", "key released", sys_rst_n, 1'b1);
        run = 1'b1;
        cyc(5);
        key_n = 1'b0;
        cyc(40);
        chk("R7", "key while running", sys_rst_n, exp_sys(1'b1, 1'b1, 1'b1));
        key_n = 1'b1;
        cyc(40);

        // R7 random key/run combinations
        for (int i = 0; i < 24; i++) begin
            logic k, r;
            k = 1'($urandom);
            r = 1'($urandom);
            key_n = !k;
            run = r;
            cyc(40);
            chk("R7", "random key/run", sys_rst_n, exp_sys(1'b1, k, r));
        end
        key_n = 1'b1;
        run = 1'b0;
        cyc(40);

        // R8 rail drop after start
        rails = 3'b110;
        cyc(10);
        chk("R8", "aux after drop", aux, 1'b0);
        chk("R8", "lamp after drop", lamp, 1'b0);
        chk("R8", "contactor after drop", contactor, 1'b0);
        chk("R8", "por_n after drop", por_n, 1'b0);
        chk("R6", "sys_rst_n after drop", sys_rst_n, 1'b0);
        chk("R8", "no lockout after drop", lockout, 1'b0);
        rails = 3'b111;
        cyc(LONG);
        chk("R9", "held request no restart", contactor, 1'b0);

        // R9 request drop during wait
        req = 1'b0;
        cyc(10);
        req = 1'b1;
        cyc(30);
        chk("R9", "edge starts", contactor, 1'b1);
        req = 1'b0;
        cyc(10);
        chk("R9", "drop in wait", contactor, 1'b0);
        cyc(LONG);
        chk("R9", "still off", por_n, 1'b0);

        // R3 lockout with random partial rails
        bad = 3'($urandom % 7);
        rails = bad;
        req = 1'b1;
        cyc(30);
        chk("R1", "aux with partial rails", aux, 1'b0);
        chk("R1", "lamp with partial rails", lamp, 1'b0);
        cyc(LONG);
        chk("R3", "contactor after timeout", contactor, 1'b0);
        chk("R3", "lockout after timeout", lockout, 1'b1);
        chk("R5", "por_n locked", por_n, 1'b0);

        // R4 retries ignored while locked
        req = 1'b0;
        cyc(10);
        rails = 3'b111;
        req = 1'b1;
        cyc(LONG);
        chk("R4", "retry ignored contactor", contactor, 1'b0);
        chk("R4", "retry ignored lockout", lockout, 1'b1);
        chk("R4", "retry ignored aux", aux, 1'b0);

        // R4 service clear
        clr = 1'b1;
        cyc(10);
        clr = 1'b0;
        cyc(10);
        chk("R4", "cleared lockout", lockout, 1'b0);
        chk("R4", "cleared contactor off", contactor, 1'b0);
        req = 1'b0;
        cyc(10);
        req = 1'b1;
        cyc(LONG + 30);
        chk("R4", "restart after clear", por_n, 1'b1);

        // R4 reset clears lockout
        req = 1'b0;
        rails = 3'b000;
        cyc(10);
        req = 1'b1;
        cyc(LONG + 30);
        chk("R3", "second lockout", lockout, 1'b1);
        rst_n = 1'b0;
        cyc(3);
        chk("R4", "reset clears lockout", lockout, 1'b0);
        chk("R11", "reset por_n", por_n, 1'b0);
        rst_n = 1'b1;
        cyc(5);

        summary();
        $finish;
    end

endmodule